// File: doc/BRIEF.md
# Role-Aware Bus Parity Generator

This block produces the even parity bit for a 32-bit multiplexed address/data bus together with its 4-bit command/byte-enable field. Parity is driven only for the bus phases that the bridge itself sources. As initiator, the bridge sources the address/command phase of every cycle and the data of write cycles. As responder, it sources the data of read cycles. In every other phase the parity output enable stays low so that another agent can drive the line.

The bit lands on the output one clock after the phase it covers. Its output enable follows the bridge's own AD enable one clock later. A data phase updates the parity value only on a clock where the side sourcing the data shows its ready strobe. During a wait state the enable stays high and the bit from the last accepted phase stays on the line. Parity that arrives from other agents is never checked and no error is reported.

Top module: `bus_parity_gen`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `par_o` and `par_oe_o` are both 0.
- R2: Whenever a value is loaded, the count of ones over the 32 `ad_i` bits, the 4 `cbe_i` bits and the resulting `par_o` is even.
- R3: On a clock with `addr_phase_i`=1, `is_master_i`=1 and `ad_oe_i`=1, the next clock shows `par_oe_o`=1 and `par_o` equal to the parity of that clock's `ad_i`/`cbe_i`, for both `is_write_i` values.
- R4: On a clock with `data_phase_i`=1, `is_master_i`=1, `is_write_i`=1, `ad_oe_i`=1 and `irdy_i`=1, the next clock shows `par_oe_o`=1 and the parity of that clock's `ad_i`/`cbe_i`.
- R5: A data phase with `is_master_i`=1 and `is_write_i`=0 gives `par_oe_o`=0 on the next clock.
- R6: On a clock with `data_phase_i`=1, `is_master_i`=0, `is_write_i`=0, `ad_oe_i`=1 and `trdy_i`=1, the next clock shows `par_oe_o`=1 and the parity of that clock's `ad_i`/`cbe_i`.
- R7: A data phase with `is_master_i`=0 and `is_write_i`=1 gives `par_oe_o`=0 on the next clock.
- R8: In a data phase that the bridge sources but where the sourcing side's ready strobe is low, `par_oe_o` is 1 on the next clock and `par_o` keeps its previous value.
- R9: An address phase with `is_master_i`=0 gives `par_oe_o`=0 on the next clock.
- R10: A clock with `ad_oe_i`=0 gives `par_oe_o`=0 on the next clock and leaves `par_o` unchanged.
- R11: Only the sourcing side's strobe counts: `irdy_i` as initiator and `trdy_i` as responder. The other strobe has no effect on `par_o`.
- R12: When `addr_phase_i` and `data_phase_i` are both 1, the clock is treated as an address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_i | input | 32 | Multiplexed address/data bus value |
| cbe_i | input | 4 | Command (address phase) or byte enables (data phase) |
| addr_phase_i | input | 1 | Current clock is an address phase |
| data_phase_i | input | 1 | Current clock is a data phase |
| is_master_i | input | 1 | 1 = bridge is initiator, 0 = bridge is responder |
| is_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| ad_oe_i | input | 1 | Bridge is driving the AD lines this clock |
| irdy_i | input | 1 | Initiator ready strobe, active high |
| trdy_i | input | 1 | Responder ready strobe, active high |
| par_o | output | 1 | Even parity bit, one clock after the covered phase |
| par_oe_o | output | 1 | Output enable for `par_o` |

## Verification
The bench covers each role and direction pair in both the address and the data phase. A design with the direction test inverted would drive parity over a read as initiator, or over a write as responder, and the enable check catches that. Wait states catch a design that reloads parity without the ready strobe or that drops the enable: the line would show the wrong bit or float. Swapped strobes, phases flagged as both address and data, and all-zero and all-ones patterns catch a design that uses the wrong ready strobe, gives data priority over address, leaves the byte-enable lanes out of the sum, or produces odd parity.

// File: rtl/bpg_pkg.sv
// Shared types for the bus parity generator.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package bpg_pkg;

    // Control decision for one clock: whether the parity line is owned
    // on the next clock, and whether a fresh parity value is loaded.
    typedef struct packed {
        logic drive;
        logic load;
    } par_ctl_t;

endpackage

// File: rtl/bpg_xor_tree.sv
// Even-parity reduction over the AD bus and the C/BE field.
// The AD bus is split into one lane per C/BE bit; each lane folds its
// byte together with its own C/BE bit, then the lane results are folded.
// Assumes AD_W is an exact multiple of CBE_W.
module bpg_xor_tree #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    output logic             par
);
    localparam int LANE_W = AD_W / CBE_W;

    logic [CBE_W-1:0] lane_par;

    for (genvar g = 0; g < CBE_W; g++) begin : g_lane
        // Per-lane fold: one byte of AD plus the matching C/BE bit.
        assign lane_par[g] = ^{ad[g*LANE_W +: LANE_W], cbe[g]};
    end

    // Final fold of the lane results gives even parity over all bits.
    assign par = ^lane_par;

    initial begin
        // Lane split requires an exact division.
        lane_split_chk: assert (AD_W % CBE_W == 0)
            else $error("AD_W must be a multiple of CBE_W");
    end
endmodule

// File: rtl/bpg_phase_ctl.sv
// Decides, for the current clock, whether the bridge owns the parity
// line on the next clock and whether a new parity value is loaded.
// Address phase wins over data phase if both are flagged.
// Assumes role and direction are steady across a bus cycle.
module bpg_phase_ctl
    import bpg_pkg::*;
(
    input  logic     addr_phase,
    input  logic     data_phase,
    input  logic     is_master,
    input  logic     is_write,
    input  logic     ad_oe,
    input  logic     irdy,
    input  logic     trdy,
    output par_ctl_t ctl
);
    logic own_data;
    logic src_ready;

    // Which side sources data, and whether its ready strobe is up.
    always_comb begin
        own_data  = is_master ? is_write : ~is_write;
        src_ready = is_master ? irdy : trdy;
    end

    // Ownership and load decision for this clock.
    always_comb begin
        ctl = '0;
        if (ad_oe) begin
            if (addr_phase) begin
                ctl.drive = is_master;
                ctl.load  = is_master;
            end else if (data_phase) begin
                ctl.drive = own_data;
                ctl.load  = own_data & src_ready;
            end
        end
    end
endmodule

// File: rtl/bpg_par_reg.sv
// Output stage: registers the parity bit and its enable one clock after
// the covered phase. The bit holds whenever no load is requested.
// Synchronous active-low reset.
module bpg_par_reg
    import bpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  par_ctl_t ctl,
    input  logic     par_next,
    output logic     par_q,
    output logic     par_oe_q
);
    // Register the enable and, on load, the new parity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q    <= 1'b0;
            par_oe_q <= 1'b0;
        end else begin
            par_oe_q <= ctl.drive;
            if (ctl.load) begin
                par_q <= par_next;
            end
        end
    end

    // R8
    hold_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.load |=> $stable(par_q));
endmodule

// File: rtl/bus_parity_gen.sv
// Role-aware even parity generator for a multiplexed AD bus.
// Drives parity only for phases this bridge sources: address phases and
// write data as initiator, read data as responder. No checking is done.
// Assumes addr/data phase flags come from the bridge's own bus sequencer.
module bus_parity_gen
    import bpg_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    input  logic             addr_phase_i,
    input  logic             data_phase_i,
    input  logic             is_master_i,
    input  logic             is_write_i,
    input  logic             ad_oe_i,
    input  logic             irdy_i,
    input  logic             trdy_i,
    output logic             par_o,
    output logic             par_oe_o
);
    par_ctl_t ctl;
    logic     par_next;

    bpg_xor_tree #(.AD_W(AD_W), .CBE_W(CBE_W)) u_tree (
        .ad  (ad_i),
        .cbe (cbe_i),
        .par (par_next)
    );

    bpg_phase_ctl u_ctl (
        .addr_phase (addr_phase_i),
        .data_phase (data_phase_i),
        .is_master  (is_master_i),
        .is_write   (is_write_i),
        .ad_oe      (ad_oe_i),
        .irdy       (irdy_i),
        .trdy       (trdy_i),
        .ctl        (ctl)
    );

    bpg_par_reg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .par_next (par_next),
        .par_q    (par_o),
        .par_oe_q (par_oe_o)
    );

    // R2
    even_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.load |=> ((^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0));

    // R5
    no_init_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master_i && !is_write_i && data_phase_i && !addr_phase_i) |=> !par_oe_o);

    // R7
    no_resp_write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master_i && is_write_i && data_phase_i && !addr_phase_i) |=> !par_oe_o);

    // R9
    no_resp_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master_i && addr_phase_i) |=> !par_oe_o);

    // R10
    oe_needs_ad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe_i |=> (!par_oe_o && $stable(par_o)));

    // R3
    init_addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master_i && addr_phase_i && ad_oe_i) |=> par_oe_o);
endmodule

// File: tb/test_bus_parity_gen.sv
module test_bus_parity_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        aph = 1'b0, dph = 1'b0, mst = 1'b0, wr = 1'b0;
    logic        adoe = 1'b0, irdy = 1'b0, trdy = 1'b0;
    logic        par, par_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic model_par = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        logic  oe;
        logic  par;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_parity_gen i_bus_parity_gen (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe),
        .addr_phase_i(aph), .data_phase_i(dph), .is_master_i(mst),
        .is_write_i(wr), .ad_oe_i(adoe), .irdy_i(irdy), .trdy_i(trdy),
        .par_o(par), .par_oe_o(par_oe)
    );

    // Driver: apply one clock of stimulus and push the expected result.
    task automatic step(input logic a, input logic d, input logic m,
                        input logic w, input logic oe, input logic ir,
                        input logic tr, input logic [31:0] adv,
                        input logic [3:0] cb, input string tag);
        exp_t e;
        logic own, load;
        @(negedge clk);
        aph = a; dph = d; mst = m; wr = w; adoe = oe;
        irdy = ir; trdy = tr; ad = adv; cbe = cb;
        own = 1'b0; load = 1'b0;
        if (oe && a) begin
            own = m; load = m;
        end else if (oe && d) begin
            own  = m ? w : !w;
            load = own && (m ? ir : tr);
        end
        if (load) model_par = ^{adv, cb};
        e.due = cyc + 1; e.oe = own; e.par = model_par; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs with due scoreboard entries.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (par_oe !== e.oe || par !== e.par) begin
                fails++;
                $display("FAIL %s: par_oe=%b par=%b expected par_oe=%b par=%b",
                         e.tag, par_oe, par, e.oe, e.par);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (par !== 1'b0 || par_oe !== 1'b0) begin
            fails++;
            $display("FAIL R1: par=%b par_oe=%b expected 0 0", par, par_oe);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (par !== 1'b0 || par_oe !== 1'b0) begin
            fails++;
            $display("FAIL R1: after release par=%b par_oe=%b expected 0 0", par, par_oe);
        end
        // R3 initiator address phases, read and write
        step(1,0,1,0,1,0,0,32'h0000_0001,4'h6,"R3");
        step(1,0,1,1,1,0,0,32'h8000_0000,4'h7,"R3");
        // R4 initiator write data with irdy
        step(0,1,1,1,1,1,0,32'hDEAD_BEEF,4'h0,"R4");
        step(0,1,1,1,1,1,1,32'h1234_5678,4'hA,"R4");
        // R2 extreme patterns
        step(0,1,1,1,1,1,0,32'hFFFF_FFFF,4'hF,"R2");
        step(0,1,1,1,1,1,0,32'h0000_0000,4'h1,"R2");
        step(0,1,1,1,1,1,0,32'h0000_0000,4'h0,"R2");
        step(0,1,1,1,1,1,0,32'h0000_0100,4'h0,"R2");
        // R8 wait state as initiator writer
        step(0,1,1,1,1,0,0,32'h0000_0007,4'h0,"R8");
        // R11 wrong strobe as initiator: trdy only
        step(0,1,1,1,1,0,1,32'h0000_0003,4'h1,"R11");
        // R5 initiator read data
        step(0,1,1,0,1,1,1,32'h0F0F_0F0F,4'h3,"R5");
        // R9 responder address phase
        step(1,0,0,0,1,1,1,32'h0000_0001,4'h2,"R9");
        // R6 responder read data with trdy
        step(0,1,0,0,1,0,1,32'hCAFE_0001,4'h0,"R6");
        step(0,1,0,0,1,0,1,32'h0000_0003,4'hF,"R6");
        // R8 responder wait state
        step(0,1,0,0,1,0,0,32'h0000_0001,4'h0,"R8");
        // R11 wrong strobe as responder: irdy only
        step(0,1,0,0,1,1,0,32'h0000_0001,4'h0,"R11");
        // R7 responder write data
        step(0,1,0,1,1,1,1,32'h0000_0001,4'h0,"R7");
        // R10 AD not driven in an otherwise owned phase
        step(1,0,1,1,0,0,0,32'h0000_0001,4'h0,"R10");
        step(0,1,1,1,0,1,0,32'h0000_0001,4'h0,"R10");
        // R12 both phase flags: address wins (initiator read would not drive data)
        step(1,1,1,0,1,0,0,32'h0000_0011,4'h1,"R12");
        // R12 responder with both flags: address wins, so no drive
        step(1,1,0,0,1,0,1,32'h0000_0001,4'h0,"R12");
        step(0,0,0,0,0,0,0,32'h0,4'h0,"R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule